// File: doc/BRIEF.md
# Relay Belief-Propagation Variable Node with Memory Bias

This block is one error-bit node of a fully parallel relay belief-propagation decoder for sparse quantum codes. Each neighbouring check sends a compressed summary rather than one message per edge. The summary holds a parity bit, the index of the edge that carried the smallest magnitude, and the smallest and second-smallest magnitudes. The node turns each summary back into the exclusive-minimum message meant for itself. It then blends its channel prior with the belief it held after the previous iteration, and sums the blended prior with all the rebuilt messages.

The blend uses a signed strength that is set per node and may be negative. It also uses a shift amount, and a pinned node skips the blend. The node saturates the total and stores it as its new belief. It returns one sign-magnitude message per edge, equal to the total with that edge's own contribution removed, together with a hard decision. All outputs are registered. They advance only in cycles where the update strobe is high, so the surrounding control decides when an iteration completes.

Top module: `relay_vnode`

## Requirements
- R1: While reset is held, and after it is released until the first update, the belief, the hard decision and every outgoing message read zero.
- R2: For each edge e, the rebuilt magnitude is the check's second-smallest magnitude when `edge_slot` field e equals `chk_pick` field e. Otherwise it is the check's smallest magnitude.
- R3: For each edge, the rebuilt message is negative exactly when `chk_par` bit e XOR the sign bit of this node's currently registered outgoing message on edge e is 1.
- R4: When not pinned, the effective prior is prior + ((strength × (belief − prior)) >>> shift_m). This uses two's-complement values, a signed product and a shift that rounds toward minus infinity. The result is clamped to ±(2^(SUM_W−1)−1), and strength may be negative.
- R5: When `pinned` is 1, the effective prior equals the channel prior, whatever the strength, shift and belief.
- R6: On an update, the belief becomes the sum of the effective prior and all rebuilt messages, clamped to ±(2^(SUM_W−1)−1). It is read out as two's complement.
- R7: On an update, outgoing field e, bits [e·MSG_W +: MSG_W], becomes the new belief minus the rebuilt message on edge e, clamped to ±(2^MAG_W−1). It is encoded with the sign in the top bit and the magnitude below it, and zero is always encoded with sign 0.
- R8: On an update, the hard decision becomes 1 exactly when the new belief is negative.
- R9: In a cycle with `upd` low, the belief, the hard decision and all outgoing messages keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd | input | 1 | Iteration strobe; registers load when high |
| chk_par | input | DEG | Parity bit from each neighbouring check |
| chk_pick | input | DEG*SEL_W | Edge index of the smallest magnitude at each check |
| chk_lo1 | input | DEG*MAG_W | Smallest magnitude at each check |
| chk_lo2 | input | DEG*MAG_W | Second-smallest magnitude at each check |
| edge_slot | input | DEG*SEL_W | This node's edge index within each check |
| prior | input | LLR_W | Channel prior, two's complement |
| strength | input | STR_W | Memory strength, two's complement |
| shift_m | input | SHIFT_W | Right-shift amount applied to the blend product |
| pinned | input | 1 | Bypass the memory blend |
| v2c_msg | output | DEG*MSG_W | Outgoing sign-magnitude messages |
| belief | output | SUM_W | Saturated total belief |
| hard_dec | output | 1 | Hard decision |

## Verification
The hardest state to reach from the ports is saturation of the belief. A pinned prior plus the message magnitudes can never reach the belief limit. The stimulus therefore leaves the node unpinned with the largest positive strength and a zero shift against a prior of opposite sign, so the belief is amplified over successive updates until the blend clamps and then the sum clamps. The sign-rebuild rule is also hard to isolate, because it depends on the node's own previous outgoing messages. Parity is toggled over consecutive updates while the bench model follows the registered signs, and negative strengths with odd products exercise the rounding of the arithmetic shift.

// File: rtl/vn_pkg.sv
package vn_pkg;

   // Largest magnitude of a symmetric two's-complement range of width w.
   function automatic int sym_max(input int w);
      return (2 ** (w - 1)) - 1;
   endfunction

   // Bits needed to add n values without overflow growth.
   function automatic int grow_bits(input int n);
      return $clog2(n + 1) + 1;
   endfunction

endpackage

// File: rtl/vn_rebuild.sv
// Rebuilds one check-to-variable message from a compressed check summary.
module vn_rebuild #(
   parameter int MAG_W = 5,
   parameter int SEL_W = 3
) (
   input  logic               parity,
   input  logic [SEL_W-1:0]   pick,
   input  logic [MAG_W-1:0]   lo1,
   input  logic [MAG_W-1:0]   lo2,
   input  logic [SEL_W-1:0]   slot,
   input  logic               prev_sign,
   output logic signed [MAG_W:0] c2v
);
   logic [MAG_W-1:0] mag;
   logic             flip;

   always_comb begin
      // this edge was the minimum: exclusive minimum is the runner-up
      mag  = (slot == pick) ? lo2 : lo1;
      flip = parity ^ prev_sign;
      c2v  = flip ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
   end
endmodule

// File: rtl/vn_mem_bias.sv
// Disordered-memory prior: prior + (strength * (belief - prior)) >>> m.
module vn_mem_bias #(
   parameter int LLR_W   = 8,
   parameter int STR_W   = 6,
   parameter int SHIFT_W = 3,
   parameter int SUM_W   = 10
) (
   input  logic signed [LLR_W-1:0] prior,
   input  logic signed [SUM_W-1:0] belief,
   input  logic signed [STR_W-1:0] strength,
   input  logic [SHIFT_W-1:0]      shift_m,
   input  logic                    pinned,
   output logic signed [SUM_W-1:0] eff
);
   localparam int DW = SUM_W + 1;
   localparam int PW = DW + STR_W;
   localparam int RW = PW + 1;
   localparam logic signed [RW-1:0] HI = RW'(vn_pkg::sym_max(SUM_W));
   localparam logic signed [RW-1:0] LO = -HI;

   logic signed [DW-1:0] diff;
   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] shd;
   logic signed [RW-1:0] raw;
   logic signed [SUM_W-1:0] blended;

   always_comb begin
      diff = DW'(belief) - DW'(prior);
      prod = PW'(strength) * PW'(diff);
      shd  = prod >>> shift_m;
      raw  = RW'(prior) + RW'(shd);
      if (raw > HI)      blended = HI[SUM_W-1:0];
      else if (raw < LO) blended = LO[SUM_W-1:0];
      else               blended = raw[SUM_W-1:0];
      eff = pinned ? SUM_W'(prior) : blended;
   end
endmodule

// File: rtl/vn_accum.sv
// Sum with saturation, then per-edge extrinsic output in sign-magnitude.
module vn_accum #(
   parameter int DEG   = 3,
   parameter int MAG_W = 5,
   parameter int SUM_W = 10
) (
   input  logic signed [SUM_W-1:0]   eff,
   input  logic [DEG*(MAG_W+1)-1:0]  c2v_flat,
   output logic signed [SUM_W-1:0]   total,
   output logic [DEG*(MAG_W+1)-1:0]  msg_flat,
   output logic                      neg
);
   localparam int CW = MAG_W + 1;
   localparam int AW = SUM_W + vn_pkg::grow_bits(DEG);
   localparam int XW = SUM_W + 2;
   localparam logic signed [AW-1:0] THI = AW'(vn_pkg::sym_max(SUM_W));
   localparam logic signed [AW-1:0] TLO = -THI;
   localparam logic signed [XW-1:0] MHI = XW'(vn_pkg::sym_max(CW));
   localparam logic signed [XW-1:0] MLO = -MHI;

   logic signed [AW-1:0] acc;

   always_comb begin
      acc = AW'(eff);
      for (int e = 0; e < DEG; e++) begin
         acc = acc + AW'($signed(c2v_flat[e*CW +: CW]));
      end
      if (acc > THI)      total = THI[SUM_W-1:0];
      else if (acc < TLO) total = TLO[SUM_W-1:0];
      else                total = acc[SUM_W-1:0];
      neg = total[SUM_W-1];
   end

   for (genvar e = 0; e < DEG; e++) begin : g_edge
      logic signed [XW-1:0] dif;
      logic signed [CW-1:0] o;
      logic [MAG_W-1:0]     mag;
      always_comb begin
         dif = XW'(total) - XW'($signed(c2v_flat[e*CW +: CW]));
         if (dif > MHI)      o = MHI[CW-1:0];
         else if (dif < MLO) o = MLO[CW-1:0];
         else                o = dif[CW-1:0];
         mag = o[CW-1] ? MAG_W'(-o) : o[MAG_W-1:0];
         msg_flat[e*CW +: CW] = {o[CW-1], mag};
      end
   end
endmodule

// File: rtl/relay_vnode.sv
// Variable node of a fully parallel relay BP decoder.
module relay_vnode #(
   parameter int DEG     = 3,
   parameter int MAG_W   = 5,
   parameter int SEL_W   = 3,
   parameter int LLR_W   = 8,
   parameter int STR_W   = 6,
   parameter int SHIFT_W = 3,
   parameter int SUM_W   = 10,
   localparam int MSG_W  = MAG_W + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   upd,
   input  logic [DEG-1:0]         chk_par,
   input  logic [DEG*SEL_W-1:0]   chk_pick,
   input  logic [DEG*MAG_W-1:0]   chk_lo1,
   input  logic [DEG*MAG_W-1:0]   chk_lo2,
   input  logic [DEG*SEL_W-1:0]   edge_slot,
   input  logic [LLR_W-1:0]       prior,
   input  logic [STR_W-1:0]       strength,
   input  logic [SHIFT_W-1:0]     shift_m,
   input  logic                   pinned,
   output logic [DEG*MSG_W-1:0]   v2c_msg,
   output logic [SUM_W-1:0]       belief,
   output logic                   hard_dec
);
   // elaboration-time parameter checks
   if (DEG < 1) begin : g_bad_deg
      $error("relay_vnode: DEG must be at least 1");
   end
   if (LLR_W > SUM_W) begin : g_bad_llr
      $error("relay_vnode: prior wider than belief");
   end
   if (MSG_W + 1 > SUM_W) begin : g_bad_msg
      $error("relay_vnode: belief must be wider than a message");
   end
   if (SUM_W + STR_W + 2 > 62) begin : g_bad_prod
      $error("relay_vnode: blend product too wide");
   end

   logic signed [SUM_W-1:0]   belief_q;
   logic [DEG*MSG_W-1:0]      v2c_q;
   logic                      hard_q;

   logic [DEG*MSG_W-1:0]      c2v_flat;
   logic signed [SUM_W-1:0]   eff;
   logic signed [SUM_W-1:0]   total;
   logic [DEG*MSG_W-1:0]      msg_next;
   logic                      neg;

   for (genvar e = 0; e < DEG; e++) begin : g_rb
      logic signed [MSG_W-1:0] c2v_e;
      vn_rebuild #(.MAG_W(MAG_W), .SEL_W(SEL_W)) u_rb (
         .parity    (chk_par[e]),
         .pick      (chk_pick[e*SEL_W +: SEL_W]),
         .lo1       (chk_lo1[e*MAG_W +: MAG_W]),
         .lo2       (chk_lo2[e*MAG_W +: MAG_W]),
         .slot      (edge_slot[e*SEL_W +: SEL_W]),
         .prev_sign (v2c_q[e*MSG_W + MSG_W - 1]),
         .c2v       (c2v_e)
      );
      assign c2v_flat[e*MSG_W +: MSG_W] = c2v_e;
   end

   vn_mem_bias #(
      .LLR_W(LLR_W), .STR_W(STR_W), .SHIFT_W(SHIFT_W), .SUM_W(SUM_W)
   ) u_bias (
      .prior    ($signed(prior)),
      .belief   (belief_q),
      .strength ($signed(strength)),
      .shift_m  (shift_m),
      .pinned   (pinned),
      .eff      (eff)
   );

   vn_accum #(.DEG(DEG), .MAG_W(MAG_W), .SUM_W(SUM_W)) u_acc (
      .eff      (eff),
      .c2v_flat (c2v_flat),
      .total    (total),
      .msg_flat (msg_next),
      .neg      (neg)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         belief_q <= '0;
         v2c_q    <= '0;
         hard_q   <= 1'b0;
      end else if (upd) begin
         belief_q <= total;
         v2c_q    <= msg_next;
         hard_q   <= neg;
      end
   end

   assign belief   = belief_q;
   assign v2c_msg  = v2c_q;
   assign hard_dec = hard_q;
endmodule

// File: rtl/vn_checker.sv
module vn_checker #(
   parameter int DEG   = 3,
   parameter int MAG_W = 5,
   parameter int SUM_W = 10
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       upd,
   input logic [DEG*(MAG_W+1)-1:0]   v2c_msg,
   input logic [SUM_W-1:0]           belief,
   input logic                       hard_dec
);
   localparam int CW = MAG_W + 1;
   localparam logic [SUM_W-1:0] MOST_NEG = {1'b1, {(SUM_W-1){1'b0}}};

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> ($stable(belief) && $stable(v2c_msg) && $stable(hard_dec))); // R9

   AST_HARD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> (hard_dec == belief[SUM_W-1])); // R8

   AST_BELIEF_SYM: assert property (@(posedge clk) disable iff (!rst_n)
      belief != MOST_NEG); // R6

   for (genvar e = 0; e < DEG; e++) begin : g_chk
      AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (v2c_msg[e*CW +: MAG_W] == '0) |-> !v2c_msg[e*CW + MAG_W]); // R7
   end
endmodule

bind relay_vnode vn_checker #(.DEG(DEG), .MAG_W(MAG_W), .SUM_W(SUM_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .upd      (upd),
   .v2c_msg  (v2c_msg),
   .belief   (belief),
   .hard_dec (hard_dec)
);

// File: tb/tb_relay_vnode.sv
module tb_relay_vnode;
   localparam int DEG = 3, MAG_W = 5, SEL_W = 3, LLR_W = 8;
   localparam int STR_W = 6, SHIFT_W = 3, SUM_W = 10;
   localparam int MSG_W = MAG_W + 1;
   localparam int BLIM = 511, MLIM = 31;

   logic clk = 1'b0, rst_n = 1'b0, upd = 1'b0, pinned = 1'b0;
   logic [DEG-1:0]       chk_par = '0;
   logic [DEG*SEL_W-1:0] chk_pick = '0, edge_slot = '0;
   logic [DEG*MAG_W-1:0] chk_lo1 = '0, chk_lo2 = '0;
   logic [LLR_W-1:0]     prior = '0;
   logic [STR_W-1:0]     strength = '0;
   logic [SHIFT_W-1:0]   shift_m = '0;
   logic [DEG*MSG_W-1:0] v2c_msg;
   logic [SUM_W-1:0]     belief;
   logic                 hard_dec;

   always #10 clk = ~clk;

   relay_vnode #(.DEG(DEG), .MAG_W(MAG_W), .SEL_W(SEL_W), .LLR_W(LLR_W),
                 .STR_W(STR_W), .SHIFT_W(SHIFT_W), .SUM_W(SUM_W)) dut (
      .clk(clk), .rst_n(rst_n), .upd(upd), .chk_par(chk_par), .chk_pick(chk_pick),
      .chk_lo1(chk_lo1), .chk_lo2(chk_lo2), .edge_slot(edge_slot), .prior(prior),
      .strength(strength), .shift_m(shift_m), .pinned(pinned),
      .v2c_msg(v2c_msg), .belief(belief), .hard_dec(hard_dec));

   int checks = 0, errors = 0;
   string tag = "R1";

   // stimulus values and reference state
   int t_par[DEG], t_pick[DEG], t_lo1[DEG], t_lo2[DEG], t_slot[DEG];
   int t_prior = 0, t_str = 0, t_shift = 0;
   bit t_pin = 0, t_upd = 0;
   int m_bel = 0;
   int m_fld[DEG];
   bit m_sgn[DEG];
   bit m_hard = 0;

   function automatic int clampv(int v, int lim);
      if (v > lim) return lim;
      if (v < -lim) return -lim;
      return v;
   endfunction

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic compare_all();
      check(tag, "belief (R6)", $signed(belief), m_bel);
      check(tag, "hard_dec (R8)", int'(hard_dec), int'(m_hard));
      for (int e = 0; e < DEG; e++)
         check(tag, $sformatf("v2c edge %0d (R7)", e),
               int'(v2c_msg[e*MSG_W +: MSG_W]), m_fld[e]);
   endtask

   task automatic drive();
      upd = t_upd; pinned = t_pin;
      prior = LLR_W'(t_prior); strength = STR_W'(t_str); shift_m = SHIFT_W'(t_shift);
      for (int e = 0; e < DEG; e++) begin
         chk_par[e] = t_par[e][0];
         chk_pick[e*SEL_W +: SEL_W] = SEL_W'(t_pick[e]);
         edge_slot[e*SEL_W +: SEL_W] = SEL_W'(t_slot[e]);
         chk_lo1[e*MAG_W +: MAG_W] = MAG_W'(t_lo1[e]);
         chk_lo2[e*MAG_W +: MAG_W] = MAG_W'(t_lo2[e]);
      end
   endtask

   // one clock: drive, predict, advance to the next falling edge, compare
   task automatic step();
      int eff, tot, sum;
      int c2v[DEG];
      drive();
      if (t_pin) eff = t_prior;                                  // R5
      else eff = clampv(t_prior + ((t_str * (m_bel - t_prior)) >>> t_shift), BLIM); // R4
      sum = eff;
      for (int e = 0; e < DEG; e++) begin
         int mag;
         mag = (t_slot[e] == t_pick[e]) ? t_lo2[e] : t_lo1[e];   // R2
         c2v[e] = ((t_par[e][0] ^ m_sgn[e]) != 0) ? -mag : mag;  // R3
         sum += c2v[e];
      end
      tot = clampv(sum, BLIM);
      @(negedge clk);
      if (t_upd) begin
         m_bel = tot;
         m_hard = (tot < 0);
         for (int e = 0; e < DEG; e++) begin
            int o;
            o = clampv(tot - c2v[e], MLIM);
            m_sgn[e] = (o < 0);
            m_fld[e] = (o < 0) ? ((1 << MAG_W) | (-o)) : o;
         end
      end
      compare_all();
   endtask

   task automatic randomize_in();
      for (int e = 0; e < DEG; e++) begin
         t_par[e] = int'($urandom_range(1, 0));
         t_pick[e] = int'($urandom_range(7, 0));
         t_slot[e] = ($urandom_range(1, 0) == 1) ? t_pick[e] : int'($urandom_range(7, 0));
         t_lo1[e] = int'($urandom_range(31, 0));
         t_lo2[e] = t_lo1[e] + int'($urandom_range(31 - t_lo1[e], 0));
      end
      t_prior = int'($urandom_range(255, 0)) - 128;
      t_str = int'($urandom_range(63, 0)) - 32;
      t_shift = int'($urandom_range(7, 0));
      t_pin = ($urandom_range(3, 0) == 0);
   endtask

   task automatic set_edges(int par, int lo1, int lo2);
      for (int e = 0; e < DEG; e++) begin
         t_par[e] = par; t_pick[e] = 0; t_slot[e] = 1; t_lo1[e] = lo1; t_lo2[e] = lo2;
      end
   endtask

   initial begin : watchdog
      #(20 * 200000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int e = 0; e < DEG; e++) begin
         t_par[e] = 0; t_pick[e] = 0; t_lo1[e] = 0; t_lo2[e] = 0; t_slot[e] = 0;
         m_fld[e] = 0; m_sgn[e] = 0;
      end
      // R1: reset state
      tag = "R1";
      repeat (3) @(negedge clk);
      compare_all();
      rst_n = 1'b1;
      @(negedge clk);
      compare_all();

      // R5: pinned prior passes through, strength and shift ignored
      tag = "R5";
      set_edges(0, 0, 0);
      t_upd = 1; t_pin = 1; t_prior = -77; t_str = 31; t_shift = 0;
      step();
      t_prior = 100; t_str = -32;
      step();

      // R2: selector match picks the runner-up magnitude
      tag = "R2";
      t_prior = 0;
      t_pick[0] = 2; t_slot[0] = 2; t_lo1[0] = 4;  t_lo2[0] = 9;
      t_pick[1] = 2; t_slot[1] = 1; t_lo1[1] = 4;  t_lo2[1] = 9;
      t_pick[2] = 5; t_slot[2] = 5; t_lo1[2] = 3;  t_lo2[2] = 12;
      for (int e = 0; e < DEG; e++) t_par[e] = 0;
      step();
      step();

      // R3: sign from parity xor own previous outgoing sign
      tag = "R3";
      set_edges(0, 6, 20);
      t_prior = -10;
      for (int k = 0; k < 6; k++) begin
         for (int e = 0; e < DEG; e++) t_par[e] = (k + e) % 2;
         step();
      end

      // R4: memory blend, negative and positive strengths
      tag = "R4";
      t_pin = 0; set_edges(1, 2, 7);
      t_prior = 40; t_str = -20; t_shift = 3;
      repeat (3) step();
      t_prior = -55; t_str = 25; t_shift = 1;
      repeat (3) step();
      t_prior = 17; t_str = -7; t_shift = 2;
      repeat (2) step();

      // R6: drive the belief into saturation via amplification
      tag = "R6";
      set_edges(0, 31, 31);
      t_pin = 1; t_prior = 127; step();
      t_pin = 0; t_prior = -128; t_str = 31; t_shift = 0;
      repeat (6) step();
      t_prior = 127; t_str = -32;
      repeat (6) step();

      // R9: no update, outputs hold under changing inputs
      tag = "R9";
      t_upd = 0;
      repeat (10) begin randomize_in(); step(); end

      // mixed random traffic
      tag = "R7";
      for (int n = 0; n < 400; n++) begin
         randomize_in();
         t_upd = ($urandom_range(4, 0) != 0);
         if ((n % 50) == 0) begin t_str = 31; t_shift = 0; t_pin = 0; end
         step();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule